// File: doc/BRIEF.md
# Stage-Gated Pipelined Multiply-Accumulate

This block sums a stream of operand products, `sum = Σ a·b`, over a run of at most N accepted operand pairs. A pair is accepted in any cycle where `in_valid` is high. It passes through four registered stages: operand capture, a carry-save reduction tree for the partial products, a ripple-carry adder that resolves the product, and a ripple-carry accumulator whose register drives `sum_out`. A pulse on `start` clears the running sum and latches the run length from `n_cfg`.

A control unit moves a one-bit token alongside every accepted pair. Each stage register loads only when the token for the stage before it is set. When no data is in flight, the downstream registers hold their values and do not toggle. Operands are two's complement when `SIGNED` is 1 (the default) and unsigned when it is 0. The accumulator is 2W + log2(NMAX) bits wide, so NMAX worst-case products cannot overflow it. NMAX must be at least 2.

Top module: `mac_stage_gated`

## Requirements
- R1: `sum_out` equals the sum of the products of all pairs accepted since the last `start`, limited to the first N of them, as an AW = 2W + clog2(NMAX) bit two's complement value.
- R2: A pair sampled at rising edge k is added into `sum_out` at edge k+3. `sum_valid` is high for the one cycle after that edge, once for each product added.
- R3: In a cycle with `in_valid` low, `a_in` and `b_in` are ignored. The cycle becomes a bubble that adds nothing.
- R4: At an edge with `start` high, the sum and the product count clear to zero, and pairs still in flight are discarded. A pair with `in_valid` high in the same cycle as `start` is the first pair of the new run.
- R5: `done` is high for exactly one cycle, together with `sum_valid`, on the cycle where the Nth product of the run appears in `sum_out`. N is latched at `start`.
- R6: Once N products have been added, later pairs are dropped. `sum_out` stays constant and `sum_valid` and `done` stay low until the next `start`.
- R7: The multiplier stage register loads only in the cycle after a pair is accepted. The adder stage loads only after the multiplier stage has loaded. The accumulator loads only after the adder stage has loaded.
- R8: With `SIGNED`=1, `a_in`, `b_in` and `sum_out` are two's complement. With `SIGNED`=0, they are unsigned.
- R9: A full run of NMAX products of the most negative operands, or of the most negative times the most positive, gives the exact sum with no wrap.
- R10: After reset, `sum_out` is 0, `sum_valid` and `done` are low, and N is 0. Nothing is accumulated before the first `start`.
- R11: An `n_cfg` above NMAX is latched as NMAX. An `n_cfg` of 0 accumulates nothing and never raises `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Clear the sum and count, latch `n_cfg` |
| in_valid | input | 1 | Accept `a_in`/`b_in` this cycle |
| a_in | input | W | First operand |
| b_in | input | W | Second operand |
| n_cfg | input | clog2(NMAX+1) | Number of products in a run |
| sum_out | output | 2W+clog2(NMAX) | Running sum of products |
| sum_valid | output | 1 | `sum_out` took a new product at the last edge |
| done | output | 1 | The Nth product of the run was just added |

## Verification
The bench aims at several failure modes:
- **Bubbles.** Streams full of bubbles carry changing operands while `in_valid` is low. A design that loads the input stage without a token would add those values in.
- **Mid-flight restart.** A `start` arrives while products are still moving through the pipe. A design that failed to flush the tokens would leak old products into the fresh sum.
- **Pair in the `start` cycle.** A pair accepted together with `start` must count as the first pair of the new run. Dropping it would give a short sum.
- **Run length.** Runs use N = 1, N = NMAX, an over-range `n_cfg` and `n_cfg` = 0, followed by extra pairs. Off-by-one counting shows up as a missing, doubled or early `done`, or as a sum that keeps moving.
- **Extreme operands.** Full runs of extreme signed operands expose any partial-product sign error or undersized accumulator as a wrong sum.

// File: rtl/mac_pkg.sv
package mac_pkg;

  // One token bit per pipeline register that carries data onward.
  typedef struct packed {
    logic in_q;   // operand register holds an accepted pair
    logic mul_q;  // carry-save register holds its sum/carry pair
    logic add_q;  // product register holds the resolved product
  } stage_tok_t;

endpackage

// File: rtl/mac_rca.sv
module mac_rca #(
  parameter int N = 16
) (
  input  logic [N-1:0] x,
  input  logic [N-1:0] y,
  output logic [N-1:0] s
);

  logic [N-1:0] c;

  assign c[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign s[i] = x[i] ^ y[i] ^ c[i];
    if (i < N - 1) begin : g_carry
      assign c[i+1] = (x[i] & y[i]) | (c[i] & (x[i] ^ y[i]));
    end
  end

endmodule

// File: rtl/mac_enable_ctrl.sv
module mac_enable_ctrl
  import mac_pkg::*;
#(
  parameter int NMAX = 16,
  parameter int CW   = $clog2(NMAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          in_valid,
  input  logic [CW-1:0] n_cfg,
  output logic          en_op,
  output logic          en_mul,
  output logic          en_add,
  output logic          en_acc,
  output logic          clr_acc,
  output logic          sum_valid,
  output logic          done
);

  localparam logic [CW-1:0] NLIM = CW'(NMAX);

  stage_tok_t    tok;
  logic [CW-1:0] n_lat;
  logic [CW-1:0] cnt;
  logic          room;
  logic          last;

  assign room    = (cnt < n_lat);
  assign last    = ((cnt + 1'b1) == n_lat);
  assign en_op   = in_valid;
  assign en_mul  = tok.in_q;
  assign en_add  = tok.mul_q;
  assign en_acc  = tok.add_q & ~start & room;
  assign clr_acc = start;

  always_ff @(posedge clk) begin
    if (rst) begin
      tok       <= '0;
      n_lat     <= '0;
      cnt       <= '0;
      sum_valid <= 1'b0;
      done      <= 1'b0;
    end else begin
      tok.in_q  <= in_valid;
      tok.mul_q <= tok.in_q & ~start;
      tok.add_q <= tok.mul_q & ~start;
      sum_valid <= en_acc;
      done      <= en_acc & last;
      if (start) begin
        n_lat <= (n_cfg > NLIM) ? NLIM : n_cfg;
        cnt   <= '0;
      end else if (en_acc) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/mac_csa_mult.sv
module mac_csa_mult #(
  parameter int W      = 8,
  parameter bit SIGNED = 1'b1
) (
  input  logic           clk,
  input  logic           en,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] sum_q,
  output logic [2*W-1:0] car_q
);

  localparam int   PW   = 2 * W;
  localparam int   ROWS = W + 1;
  localparam logic SG   = SIGNED;

  typedef logic [PW-1:0] row_t;

  function automatic row_t ext_op(input logic [W-1:0] v);
    return {{W{v[W-1] & SG}}, v};
  endfunction

  // Wallace-style reduction: rows are grouped in threes and compressed
  // by full adders level after level until a sum/carry pair remains.
  function automatic logic [2*PW-1:0] csa_tree(input logic [W-1:0] x,
                                               input logic [W-1:0] y);
    row_t r   [ROWS];
    row_t nxt [ROWS];
    row_t xe;
    row_t p;
    row_t q;
    row_t t;
    int   n;
    int   m;
    xe = ext_op(x);
    for (int i = 0; i < W; i++) r[i] = y[i] ? (xe << i) : '0;
    r[W] = '0;
    if (SG && y[W-1]) begin
      r[W-1] = ~(xe << (W - 1));
      r[W]   = row_t'(1);
    end
    n = ROWS;
    for (int lvl = 0; lvl < ROWS; lvl++) begin
      if (n > 2) begin
        m = 0;
        for (int k = 0; k < ROWS; k++) nxt[k] = '0;
        for (int g = 0; g < ROWS; g += 3) begin
          if (g + 2 < n) begin
            p = r[g];
            q = r[g+1];
            t = r[g+2];
            nxt[m]   = p ^ q ^ t;
            nxt[m+1] = ((p & q) | (p & t) | (q & t)) << 1;
            m = m + 2;
          end else if (g < n) begin
            nxt[m] = r[g];
            m = m + 1;
            if (g + 1 < n) begin
              nxt[m] = r[g+1];
              m = m + 1;
            end
          end
        end
        for (int k = 0; k < ROWS; k++) r[k] = nxt[k];
        n = m;
      end
    end
    return {r[0], r[1]};
  endfunction

  logic [2*PW-1:0] pair_n;

  assign pair_n = csa_tree(a, b);

  always_ff @(posedge clk) begin
    if (en) begin
      sum_q <= pair_n[2*PW-1:PW];
      car_q <= pair_n[PW-1:0];
    end
  end

endmodule

// File: rtl/mac_accum.sv
module mac_accum #(
  parameter int PW     = 16,
  parameter int AW     = 20,
  parameter bit SIGNED = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          en_add,
  input  logic          en_acc,
  input  logic [PW-1:0] sv,
  input  logic [PW-1:0] cv,
  output logic [AW-1:0] sum_out
);

  localparam int   XW = AW - PW;
  localparam logic SG = SIGNED;

  logic [PW-1:0] prod_n;
  logic [PW-1:0] prod_q;
  logic [AW-1:0] prod_x;
  logic [AW-1:0] acc_n;
  logic [AW-1:0] acc_q;

  mac_rca #(.N(PW)) u_final (.x(sv), .y(cv), .s(prod_n));

  always_ff @(posedge clk) begin
    if (en_add) prod_q <= prod_n;
  end

  assign prod_x = {{XW{prod_q[PW-1] & SG}}, prod_q};

  mac_rca #(.N(AW)) u_running (.x(acc_q), .y(prod_x), .s(acc_n));

  always_ff @(posedge clk) begin
    if (rst || clr)  acc_q <= '0;
    else if (en_acc) acc_q <= acc_n;
  end

  assign sum_out = acc_q;

endmodule

// File: rtl/mac_stage_gated.sv
module mac_stage_gated #(
  parameter int W      = 8,
  parameter int NMAX   = 16,
  parameter bit SIGNED = 1'b1
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             start,
  input  logic                             in_valid,
  input  logic [W-1:0]                     a_in,
  input  logic [W-1:0]                     b_in,
  input  logic [$clog2(NMAX+1)-1:0]        n_cfg,
  output logic [2*W+$clog2(NMAX)-1:0]      sum_out,
  output logic                             sum_valid,
  output logic                             done
);

  localparam int PW = 2 * W;
  localparam int CW = $clog2(NMAX + 1);
  localparam int AW = PW + $clog2(NMAX);

  logic          en_op;
  logic          en_mul;
  logic          en_add;
  logic          en_acc;
  logic          clr_acc;
  logic [W-1:0]  a_q;
  logic [W-1:0]  b_q;
  logic [PW-1:0] sv_q;
  logic [PW-1:0] cv_q;

  always_ff @(posedge clk) begin
    if (en_op) begin
      a_q <= a_in;
      b_q <= b_in;
    end
  end

  mac_enable_ctrl #(.NMAX(NMAX), .CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .in_valid(in_valid), .n_cfg(n_cfg),
    .en_op(en_op), .en_mul(en_mul), .en_add(en_add), .en_acc(en_acc),
    .clr_acc(clr_acc), .sum_valid(sum_valid), .done(done)
  );

  mac_csa_mult #(.W(W), .SIGNED(SIGNED)) u_mult (
    .clk(clk), .en(en_mul), .a(a_q), .b(b_q), .sum_q(sv_q), .car_q(cv_q)
  );

  mac_accum #(.PW(PW), .AW(AW), .SIGNED(SIGNED)) u_acc (
    .clk(clk), .rst(rst), .clr(clr_acc), .en_add(en_add), .en_acc(en_acc),
    .sv(sv_q), .cv(cv_q), .sum_out(sum_out)
  );

endmodule

// File: rtl/mac_stage_gated_chk.sv
module mac_stage_gated_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          in_valid,
  input logic          en_mul,
  input logic          en_add,
  input logic          en_acc,
  input logic [AW-1:0] sum_out,
  input logic          sum_valid,
  input logic          done
);

  AST_MUL_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst) en_mul |-> $past(in_valid)); // R7
  AST_ADD_AFTER_MUL: assert property (@(posedge clk) disable iff (rst) en_add |-> $past(en_mul)); // R7
  AST_ACC_AFTER_ADD: assert property (@(posedge clk) disable iff (rst) en_acc |-> $past(en_add)); // R2
  AST_VALID_AFTER_ACC: assert property (@(posedge clk) disable iff (rst) sum_valid |-> $past(en_acc)); // R2
  AST_SUM_HOLDS: assert property (@(posedge clk) disable iff (rst) (!en_acc && !start) |=> $stable(sum_out)); // R6
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst) start |=> (sum_out == '0) && !sum_valid && !done); // R4
  AST_DONE_WITH_VALID: assert property (@(posedge clk) disable iff (rst) done |-> sum_valid); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R5

endmodule

bind mac_stage_gated mac_stage_gated_chk #(.AW(AW)) i_chk (
  .clk(clk), .rst(rst), .start(start), .in_valid(in_valid),
  .en_mul(en_mul), .en_add(en_add), .en_acc(en_acc),
  .sum_out(sum_out), .sum_valid(sum_valid), .done(done)
);

// File: tb/test_mac_stage_gated.sv
module test_mac_stage_gated;

  localparam int W    = 8;
  localparam int NMAX = 16;
  localparam int CW   = $clog2(NMAX + 1);
  localparam int AW   = 2 * W + $clog2(NMAX);

  logic          clk = 1'b0;
  logic          rst;
  logic          start;
  logic          in_valid;
  logic [W-1:0]  a_in;
  logic [W-1:0]  b_in;
  logic [CW-1:0] n_cfg;
  logic [AW-1:0] sum_out;
  logic          sum_valid;
  logic          done;

  always #5 clk = ~clk;

  mac_stage_gated #(.W(W), .NMAX(NMAX), .SIGNED(1'b1)) i_mac_stage_gated (
    .clk(clk), .rst(rst), .start(start), .in_valid(in_valid),
    .a_in(a_in), .b_in(b_in), .n_cfg(n_cfg),
    .sum_out(sum_out), .sum_valid(sum_valid), .done(done)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    ended = 0;
  string req   = "R10";

  // Reference: products in flight, running sum, count, run length.
  bit     pv [3];
  longint pp [3];
  longint m_acc;
  int     m_cnt;
  int     m_n;
  bit     m_sv;
  bit     m_done;
  int     done_seen;

  function automatic longint ref_prod(input logic [W-1:0] x, input logic [W-1:0] y);
    return longint'($signed(x)) * longint'($signed(y));
  endfunction

  function automatic int clamp_n(input int v);
    return (v > NMAX) ? NMAX : v;
  endfunction

  task automatic model_edge();
    bit add_now;
    if (rst) begin
      for (int i = 0; i < 3; i++) pv[i] = 0;
      m_acc = 0; m_cnt = 0; m_n = 0; m_sv = 0; m_done = 0;
      return;
    end
    add_now = pv[2] && !start && (m_cnt < m_n);
    m_sv    = add_now;
    m_done  = add_now && (m_cnt + 1 == m_n);
    if (start) begin
      m_acc = 0; m_cnt = 0; m_n = clamp_n(int'(n_cfg));
    end else if (add_now) begin
      m_acc = m_acc + pp[2]; m_cnt = m_cnt + 1;
    end
    pv[2] = pv[1] && !start; pp[2] = pp[1];
    pv[1] = pv[0] && !start; pp[1] = pp[0];
    pv[0] = in_valid;
    if (in_valid) pp[0] = ref_prod(a_in, b_in);
  endtask

  task automatic compare();
    logic [AW-1:0] exp_sum;
    exp_sum = m_acc[AW-1:0];
    n_cmp++;
    if (sum_out !== exp_sum || sum_valid !== m_sv || done !== m_done) begin
      n_bad++;
      $display("FAIL %s: sum/valid/done actual %h/%0b/%0b expected %h/%0b/%0b",
               req, sum_out, sum_valid, done, exp_sum, m_sv, m_done);
    end
    if (done === 1'b1) done_seen++;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    model_edge();
    compare();
  endtask

  task automatic drive(input bit st, input bit v, input logic [W-1:0] a,
                       input logic [W-1:0] b, input int n);
    start = st; in_valid = v; a_in = a; b_in = b; n_cfg = CW'(n);
    tick();
  endtask

  task automatic idle(input int cycles);
    for (int i = 0; i < cycles; i++) drive(0, 0, W'($urandom), W'($urandom), 0);
  endtask

  task automatic check_eq(input string r, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1; start = 0; in_valid = 0; a_in = '0; b_in = '0; n_cfg = '0;
    for (int i = 0; i < 3; i++) tick();
    rst = 0;

    // R10: reset state, nothing accumulates before the first start
    req = "R10";
    check_eq("R10 sum after reset", longint'(sum_out), 0);
    for (int i = 0; i < 8; i++) drive(0, 1, W'($urandom), W'($urandom), 0);
    idle(4);
    check_eq("R10 sum before start", longint'(sum_out), 0);

    // R2: single product 5*3, exact arrival cycle
    req = "R2";
    drive(1, 0, 0, 0, 4);
    drive(0, 1, 8'd5, 8'd3, 0);
    idle(5);
    check_eq("R2 single product", longint'(sum_out), 15);

    // R1 / R8: signed stream, back to back
    req = "R8";
    drive(1, 0, 0, 0, NMAX);
    drive(0, 1, 8'hFF, 8'hFF, 0);
    drive(0, 1, 8'h80, 8'h03, 0);
    drive(0, 1, 8'h7F, 8'hF9, 0);
    req = "R1";
    for (int i = 0; i < 13; i++) drive(0, 1, W'($urandom), W'($urandom), 0);
    idle(5);

    // R6: further pairs after the Nth are dropped
    req = "R6";
    for (int i = 0; i < 6; i++) drive(0, 1, W'($urandom), W'($urandom), 0);
    idle(5);

    // R3: bubbles with noisy operands
    req = "R3";
    drive(1, 0, 0, 0, 8);
    for (int i = 0; i < 30; i++) drive(0, (i % 4) == 1, W'($urandom), W'($urandom), 0);
    idle(5);

    // R9: extreme operands over a full run
    req = "R9";
    drive(1, 0, 0, 0, NMAX);
    for (int i = 0; i < NMAX; i++) drive(0, 1, 8'h80, 8'h80, 0);
    idle(5);
    check_eq("R9 max positive sum", longint'($signed(sum_out)), 16384 * NMAX);
    drive(1, 0, 0, 0, NMAX);
    for (int i = 0; i < NMAX; i++) drive(0, 1, 8'h80, 8'h7F, 0);
    idle(5);
    check_eq("R9 max negative sum", longint'($signed(sum_out)), -16256 * NMAX);

    // R4: restart with products in flight, pair in the start cycle
    req = "R4";
    drive(1, 0, 0, 0, 5);
    drive(0, 1, 8'd9, 8'd9, 0);
    drive(0, 1, 8'd7, 8'd7, 0);
    drive(1, 1, 8'd2, 8'd11, 3);
    idle(5);
    check_eq("R4 restart keeps start-cycle pair", longint'(sum_out), 22);

    // R5: done pulses once for N = 3 and N = 1
    req = "R5";
    done_seen = 0;
    drive(1, 0, 0, 0, 3);
    for (int i = 0; i < 5; i++) drive(0, 1, W'($urandom), W'($urandom), 0);
    idle(5);
    check_eq("R5 done count N=3", done_seen, 1);
    done_seen = 0;
    drive(1, 1, 8'd6, 8'd7, 1);
    drive(0, 1, 8'd9, 8'd9, 0);
    idle(5);
    check_eq("R5 done count N=1", done_seen, 1);
    check_eq("R5 sum N=1", longint'(sum_out), 42);

    // R11: over-range and zero run lengths
    req = "R11";
    done_seen = 0;
    drive(1, 0, 0, 0, (1 << CW) - 1);
    for (int i = 0; i < NMAX + 4; i++) drive(0, 1, 8'd1, 8'd1, 0);
    idle(5);
    check_eq("R11 clamp to NMAX", longint'(sum_out), NMAX);
    drive(1, 0, 0, 0, 0);
    for (int i = 0; i < 6; i++) drive(0, 1, 8'd3, 8'd3, 0);
    idle(5);
    check_eq("R11 zero length sum", longint'(sum_out), 0);
    check_eq("R11 done only once", done_seen, 1);

    // R1: random runs with random lengths and bubble density
    req = "R1";
    for (int run = 0; run < 40; run++) begin
      int len;
      int dens;
      len  = 1 + int'($urandom % NMAX);
      dens = 1 + int'($urandom % 4);
      drive(1, ($urandom % 2) == 0, W'($urandom), W'($urandom), len);
      for (int i = 0; i < 24; i++)
        drive(0, ($urandom % dens) == 0, W'($urandom), W'($urandom), 0);
      idle(4);
    end

    finish_run();
  end

endmodule